// File: doc/BRIEF.md
# Per-Area Memory Wait-State Controller

This block paces CPU accesses to an external memory that is divided into four address areas. When an access is accepted, the block takes the area from the two most significant address bits. It then works out how many wait cycles that area needs, holds the access for that many cycles and raises a one-cycle completion pulse. The wait count comes from two settings. One is a 2-bit wait selector for each area. The other is a 2-bit long-wait extension. Areas 0 and 1 each have their own extension, and areas 2 and 3 share one.

Before it counts, the block decides whether the access needs bus ownership from an external arbiter. If it does, the block raises a bus request and waits for the grant before the count begins. It holds the request until the access completes. In partial-share mode, while the block is the bus master, only area 2 is shared and the other areas go straight to counting. Partial-share mode also switches off the address-monitor enable output.

Configuration is written through a write-enable port with two register selects. All settings are captured when an access is accepted, so a write that lands during an access changes only later accesses.

Top module: `memwait_ctrl`

## Requirements
- R1: The target area is `req_addr[ADDR_W-1:ADDR_W-2]`, and each area uses its own 2-bit wait selector. The selector for area n sits at bits [2n+1:2n] of the wait register (`cfg_sel`=0, bits [7:0]).
- R2: Selector codes 00, 01 and 10 give 0, 1 and 2 wait cycles.
- R3: Selector code 11 on an area that uses the basic interface gives 3, 4, 5 or 6 wait cycles, for extension codes 00, 01, 10 and 11.
- R4: The control register is written with `cfg_sel`=1. Its extension fields are: area 0 at bits [2:1], area 1 at bits [4:3], and areas 2 and 3 sharing bits [6:5].
- R5: Bits [10:7] of the control register mark areas 0 to 3 as basic interface (1). Code 11 on a non-basic area always gives 3 wait cycles, whatever the extension field holds.
- R6: A shared access asserts `bus_req` and does not count down until `bus_gnt` is sampled high. `bus_req` then stays high through the completion cycle.
- R7: Partial-share mode is control bit 0. With partial-share mode set and `master_mode` high, only area 2 requests the bus. In every other case, every access requests the bus.
- R8: `addr_mon_en` is low exactly when partial-share mode is set.
- R9: After reset, every wait selector is 11, every extension is 00, partial-share mode is 0 and every area is basic. Every access therefore takes 3 waits and requests the bus.
- R10: `acc_done` is a one-cycle pulse. `req_ready` is high only when the block is idle, and a request made while busy is ignored.
- R11: A configuration write during an access does not change that access's wait count or its bus-request decision.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0: wait selector register, 1: control register |
| cfg_wdata | input | 16 | Write data |
| master_mode | input | 1 | High when this side is the bus master |
| req_valid | input | 1 | Access request |
| req_addr | input | ADDR_W | Access address |
| req_ready | output | 1 | High when idle, so a request is accepted |
| acc_done | output | 1 | One-cycle completion pulse |
| bus_req | output | 1 | Bus ownership request to the arbiter |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| addr_mon_en | output | 1 | Address-monitor enable |

## Verification
Counting from the clock edge that accepts an access, an access that does not need the bus raises `acc_done` after exactly w further edges, where w is the expected wait count. A shared access first spends one cycle for every sample with the grant low, plus the cycle in which the grant is seen, and then spends w more. The bench samples on falling edges and counts the low samples of `acc_done` after acceptance. It compares that count with a value computed from its own copy of the configuration, taken at acceptance. Register writes take effect one edge after the write strobe, so `addr_mon_en` and the next access are checked only after that edge.

// File: rtl/memwait_ctrl.sv
module memwait_ctrl #(
  parameter int ADDR_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic              cfg_sel,
  input  logic [15:0]       cfg_wdata,
  input  logic              master_mode,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_addr,
  output logic              req_ready,
  output logic              acc_done,
  output logic              bus_req,
  input  logic              bus_gnt,
  output logic              addr_mon_en
);

  localparam int CNT_W  = 3;
  localparam int AREAS  = 4;

  typedef enum logic [1:0] {S_IDLE, S_ARB, S_WAIT} state_t;

  logic [2*AREAS-1:0] wsel;
  logic [1:0]         ext0, ext1, ext23;
  logic [AREAS-1:0]   basic;
  logic               pshare;

  state_t             state;
  logic [CNT_W-1:0]   cnt;
  logic               shared_q;

  logic [1:0]         area;
  logic [1:0]         code;
  logic [1:0]         ext;
  logic [CNT_W-1:0]   new_cnt;
  logic               need_bus;

  assign area = req_addr[ADDR_W-1 -: 2];
  assign code = wsel[2*area +: 2];
  assign ext  = (area == 2'd0) ? ext0 : (area == 2'd1) ? ext1 : ext23;

  always_comb begin
    if (code != 2'b11)       new_cnt = CNT_W'(code);
    else if (basic[area])    new_cnt = CNT_W'(3) + CNT_W'(ext);
    else                     new_cnt = CNT_W'(3);
  end

  assign need_bus    = !(pshare && master_mode) || (area == 2'd2);
  assign req_ready   = (state == S_IDLE);
  assign acc_done    = (state == S_WAIT) && (cnt == '0);
  assign bus_req     = (state == S_ARB) || ((state == S_WAIT) && shared_q);
  assign addr_mon_en = !pshare;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wsel   <= '1;
      ext0   <= '0;
      ext1   <= '0;
      ext23  <= '0;
      basic  <= '1;
      pshare <= 1'b0;
    end else if (cfg_we) begin
      if (!cfg_sel) begin
        wsel <= cfg_wdata[2*AREAS-1:0];
      end else begin
        pshare <= cfg_wdata[0];
        ext0   <= cfg_wdata[2:1];
        ext1   <= cfg_wdata[4:3];
        ext23  <= cfg_wdata[6:5];
        basic  <= cfg_wdata[10:7];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cnt      <= '0;
      shared_q <= 1'b0;
    end else begin
      unique case (state)
        S_IDLE: if (req_valid) begin
          cnt      <= new_cnt;
          shared_q <= need_bus;
          state    <= need_bus ? S_ARB : S_WAIT;
        end
        S_ARB:  if (bus_gnt) state <= S_WAIT;
        S_WAIT: if (cnt == '0) state <= S_IDLE;
                else           cnt   <= cnt - 1'b1;
        default: state <= S_IDLE;
      endcase
    end
  end

  p_done_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> !acc_done);

  p_idle_after_done_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc_done |=> req_ready);

  p_req_held_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !acc_done) |=> bus_req);

  p_no_done_at_request_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_req) |-> !acc_done);

  p_cnt_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CNT_W'(6));

  p_busy_no_ready_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (req_ready && req_valid) |=> !req_ready);

endmodule

// File: tb/memwait_ctrl_bench.sv
module memwait_ctrl_bench;
  localparam int ADDR_W = 16;

  logic clk = 0, rst_n = 0;
  logic cfg_we = 0, cfg_sel = 0;
  logic [15:0] cfg_wdata = '0;
  logic master_mode = 0, req_valid = 0, bus_gnt = 0;
  logic [ADDR_W-1:0] req_addr = '0;
  logic req_ready, acc_done, bus_req, addr_mon_en;

  int checks = 0, failures = 0, cyc = 0;

  logic [7:0] m_wsel = 8'hFF;
  logic [1:0] m_ext0 = 0, m_ext1 = 0, m_ext23 = 0;
  logic [3:0] m_basic = 4'hF;
  logic       m_pshare = 0;

  memwait_ctrl #(.ADDR_W(ADDR_W)) u_memwait_ctrl (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
    .master_mode(master_mode), .req_valid(req_valid), .req_addr(req_addr),
    .req_ready(req_ready), .acc_done(acc_done), .bus_req(bus_req), .bus_gnt(bus_gnt),
    .addr_mon_en(addr_mon_en));

  always #5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      failures = failures + 1;
      $display("FAIL watchdog: act=hung exp=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input bit ok, input string rq, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: act=%0d exp=%0d", rq, act, exp);
    end
  endtask

  function automatic int exp_wait(input logic [1:0] a);
    logic [1:0] c, e;
    c = m_wsel[2*a +: 2];
    e = (a == 0) ? m_ext0 : (a == 1) ? m_ext1 : m_ext23;
    if (c != 2'b11) return int'(c);
    if (m_basic[a]) return 3 + int'(e);
    return 3;
  endfunction

  function automatic bit exp_share(input logic [1:0] a);
    return !(m_pshare && master_mode) || a == 2;
  endfunction

  task automatic mirror(input bit sel, input logic [15:0] d);
    if (!sel) m_wsel = d[7:0];
    else begin
      m_pshare = d[0]; m_ext0 = d[2:1]; m_ext1 = d[4:3];
      m_ext23 = d[6:5]; m_basic = d[10:7];
    end
  endtask

  task automatic cfg_write(input bit sel, input logic [15:0] d);
    @(negedge clk);
    cfg_we = 1; cfg_sel = sel; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 0;
    mirror(sel, d);
    chk(addr_mon_en == !m_pshare, "R8", addr_mon_en, !m_pshare);
  endtask

  task automatic access(input logic [1:0] a, input int g, input bit midwrite,
                        input bit poke, input string rq);
    int w, lows, exp;
    bit sh;
    logic [15:0] d;
    w = exp_wait(a);
    sh = exp_share(a);
    @(negedge clk);
    chk(req_ready == 1, "R10", req_ready, 1);
    req_valid = 1;
    req_addr = {a, 14'($urandom)};
    @(negedge clk);
    req_valid = 0;
    lows = 0;
    for (int j = 0; j < 40; j++) begin
      if (acc_done) break;
      chk(bus_req == sh, "R7", bus_req, sh);
      chk(req_ready == 0, "R10", req_ready, 0);
      if (midwrite && j == 0) begin
        d = 16'($urandom);
        cfg_we = 1; cfg_sel = d[15]; cfg_wdata = d;
      end
      if (poke && j == 0) begin
        req_valid = 1;
        req_addr = 16'($urandom);
      end
      if (sh && j == g) bus_gnt = 1;
      lows++;
      @(negedge clk);
      if (cfg_we) begin
        cfg_we = 0;
        mirror(cfg_sel, cfg_wdata);
      end
      req_valid = 0;
    end
    bus_gnt = 0;
    exp = w + (sh ? g + 1 : 0);
    chk(lows == exp, rq, lows, exp);
    chk(acc_done == 1, rq, acc_done, 1);
    if (sh) chk(bus_req == 1, "R6", bus_req, 1);
    @(negedge clk);
    chk(acc_done == 0, "R10", acc_done, 0);
    chk(req_ready == 1, "R10", req_ready, 1);
    chk(bus_req == 0, "R6", bus_req, 0);
    if (poke) begin
      @(negedge clk);
      chk(acc_done == 0, "R10", acc_done, 0);
      chk(req_ready == 1, "R10", req_ready, 1);
    end
  endtask

  initial begin
    void'($urandom(32'h5EED1));
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready == 1, "R9", req_ready, 1);
    chk(acc_done == 0, "R9", acc_done, 0);
    chk(bus_req == 0, "R9", bus_req, 0);
    chk(addr_mon_en == 1, "R9", addr_mon_en, 1);

    for (int a = 0; a < 4; a++) access(2'(a), 0, 0, 0, "R9");

    cfg_write(0, 16'b11_10_01_00);
    for (int a = 0; a < 3; a++) access(2'(a), 1, 0, 0, "R2");
    access(2'd3, 2, 0, 0, "R1");

    cfg_write(0, 16'hFF);
    cfg_write(1, 16'b1111_10_01_11_0);
    access(2'd0, 0, 0, 0, "R4");
    access(2'd1, 0, 0, 0, "R4");
    access(2'd2, 0, 0, 0, "R3");
    access(2'd3, 3, 0, 0, "R4");

    cfg_write(1, 16'b1010_11_11_11_0);
    access(2'd0, 0, 0, 0, "R5");
    access(2'd1, 0, 0, 0, "R5");
    access(2'd2, 0, 0, 0, "R5");

    master_mode = 1;
    cfg_write(1, 16'b1111_00_00_00_1);
    for (int a = 0; a < 4; a++) access(2'(a), 2, 0, 0, "R7");
    master_mode = 0;
    access(2'd0, 1, 0, 0, "R7");
    master_mode = 1;

    access(2'd2, 4, 0, 0, "R6");
    access(2'd1, 0, 1, 0, "R11");
    access(2'd3, 1, 1, 1, "R11");
    access(2'd0, 0, 0, 1, "R10");

    for (int i = 0; i < 60; i++) begin
      if ($urandom_range(0, 2) == 0) cfg_write(1'($urandom), 16'($urandom));
      master_mode = 1'($urandom);
      access(2'($urandom), $urandom_range(0, 3), 1'($urandom_range(0, 3) == 0), 0, "R3");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule